// File: doc/BRIEF.md
# Twisted-Pair Link Integrity Monitor

This block decides whether a 10BASE-T twisted-pair link is usable. It watches two qualified inputs from the receive front end: a one-cycle strobe for each detected link test pulse, and a level that is high while receive data is present. From these it keeps a link state that starts failed, becomes good once the far end proves it is alive, and falls back to failed after a long silence.

Recovery from the failed state needs a run of link pulses whose spacing is neither too short nor too long. A pulse that comes too soon empties the run. A pulse that comes after too long a gap starts a new run. Real receive data brings the link back at once. While the link is good, every pulse or burst of receive data restarts a loss timer, and the link fails when that timer runs out. A test-disable input holds the link good for diagnostics.

All time limits are given in milliseconds and turned into clock cycles from a clock-frequency parameter. The outputs are plain control and status pins with no handshake: a status bit, and a blocking signal that gates the transmit and receive paths while the link is down.

Top module: `tp_link_monitor`

## Requirements
- R1: After reset `link_ok` is 0 and `path_block` is 1.
- R2: While the link is good, if neither `lp_strobe` nor `rx_active` is sampled for LOSS_MS worth of cycles, `link_ok` falls on the edge exactly LOSS_MS*CLK_HZ/1000 edges after the edge that sampled the last event.
- R3: While the link is good, each sampled `lp_strobe` or `rx_active` restarts the loss window from that edge.
- R4: Pulse spacing is the number of clock edges between the edges that sample two strobes. While the link is failed, a pulse whose spacing lies within [MIN_GAP_MS, MAX_GAP_MS] (both limits included) extends the run. `link_ok` rises on the edge that samples the LINK_COUNT-th pulse of a run.
- R5: While the link is failed, a pulse with spacing below MIN_GAP_MS empties the run. That pulse still becomes the reference for measuring the next spacing.
- R6: While the link is failed, a pulse with spacing above MAX_GAP_MS, or the first pulse after reset, starts a new run of length 1.
- R7: While the link is failed, a sampled `rx_active` makes `link_ok` 1 on that edge. When it arrives in the same cycle as a pulse, it takes priority over the pulse.
- R8: `path_block` is always the inverse of `link_ok`.
- R9: While `test_off` is sampled high, `link_ok` is 1, whatever the silence on the inputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| lp_strobe | input | 1 | One-cycle strobe per qualified link test pulse |
| rx_active | input | 1 | High while receive data activity is present |
| test_off | input | 1 | Link test disabled; link forced good |
| link_ok | output | 1 | Link-good status bit |
| path_block | output | 1 | High while transmit and receive must be blocked |

## Verification
Each result is registered once. A strobe or activity sampled at one edge shows on `link_ok` and `path_block` right after that same edge. A loss shows exactly LOSS cycles after the edge of the last event. The bench records the edge index of every stimulus it drives and queues each expected level against an exact edge number: the edge itself, the one before a boundary, and the one after. A monitor compares each queued level half a cycle after its edge, and any item that is overdue counts as a failure.

// File: rtl/tp_link_pkg.sv
package tp_link_pkg;

  typedef enum logic {
    LINK_DOWN = 1'b0,
    LINK_UP   = 1'b1
  } link_state_t;

  function automatic int ms_to_cycles(input int clk_hz, input int ms);
    return (clk_hz / 1000) * ms;
  endfunction

endpackage

// File: rtl/tp_pulse_spacing.sv
module tp_pulse_spacing #(
  parameter int MIN_CYC = 4,
  parameter int MAX_CYC = 64
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pulse,
  output logic too_soon,
  output logic too_late
);
  localparam int SAT = MAX_CYC + 1;
  localparam int W   = $clog2(SAT + 1);
  localparam logic [W-1:0] SAT_V = W'(SAT);
  localparam logic [W-1:0] MIN_V = W'(MIN_CYC);
  localparam logic [W-1:0] MAX_V = W'(MAX_CYC);

  // cycles since the last pulse; saturated value means "no usable reference"
  logic [W-1:0] since_q;

  always_ff @(posedge clk) begin
    if (!rst_n)                since_q <= SAT_V;
    else if (pulse)            since_q <= W'(1);
    else if (since_q != SAT_V) since_q <= since_q + W'(1);
  end

  assign too_soon = since_q < MIN_V;
  assign too_late = since_q > MAX_V;

  assert_spacing_class_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({too_soon, too_late}));

  assert_fresh_reference_R6: assert property (@(posedge clk) disable iff (!rst_n)
    pulse |=> (MIN_CYC > 1) ? too_soon : !too_late);

endmodule

// File: rtl/tp_loss_timer.sv
module tp_loss_timer #(
  parameter int LOSS_CYC = 64
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  input  logic kick,
  output logic expire
);
  localparam int W = (LOSS_CYC > 1) ? $clog2(LOSS_CYC) : 1;
  localparam logic [W-1:0] LAST = W'(LOSS_CYC - 1);

  logic [W-1:0] quiet_q;

  always_ff @(posedge clk) begin
    if (!rst_n)               quiet_q <= '0;
    else if (!run || kick)    quiet_q <= '0;
    else if (quiet_q != LAST) quiet_q <= quiet_q + W'(1);
  end

  assign expire = run && !kick && (quiet_q == LAST);

  assert_expire_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n)
    expire |-> $past(run && !kick));

  assert_kick_restarts_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (run && kick && LOSS_CYC > 1) |=> !expire);

endmodule

// File: rtl/tp_link_monitor.sv
module tp_link_monitor
  import tp_link_pkg::*;
#(
  parameter int CLK_HZ     = 25_000_000,
  parameter int LOSS_MS    = 64,
  parameter int MIN_GAP_MS = 4,
  parameter int MAX_GAP_MS = 64,
  parameter int LINK_COUNT = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic lp_strobe,
  input  logic rx_active,
  input  logic test_off,
  output logic link_ok,
  output logic path_block
);
  localparam int LOSS_CYC = ms_to_cycles(CLK_HZ, LOSS_MS);
  localparam int MIN_CYC  = ms_to_cycles(CLK_HZ, MIN_GAP_MS);
  localparam int MAX_CYC  = ms_to_cycles(CLK_HZ, MAX_GAP_MS);
  localparam int CW       = $clog2(LINK_COUNT + 1);
  localparam logic [CW-1:0] GOAL = CW'(LINK_COUNT);

  link_state_t   state_q;
  logic [CW-1:0] run_q;
  logic          too_soon, too_late, expire;

  tp_pulse_spacing #(.MIN_CYC(MIN_CYC), .MAX_CYC(MAX_CYC)) u_spacing (
    .clk(clk), .rst_n(rst_n), .pulse(lp_strobe),
    .too_soon(too_soon), .too_late(too_late)
  );

  tp_loss_timer #(.LOSS_CYC(LOSS_CYC)) u_loss (
    .clk(clk), .rst_n(rst_n),
    .run(state_q == LINK_UP && !test_off),
    .kick(lp_strobe || rx_active),
    .expire(expire)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= LINK_DOWN;
      run_q   <= '0;
    end else if (test_off) begin
      state_q <= LINK_UP;
      run_q   <= '0;
    end else if (state_q == LINK_UP) begin
      if (expire) begin
        state_q <= LINK_DOWN;
        run_q   <= '0;
      end
    end else if (rx_active) begin
      state_q <= LINK_UP;
      run_q   <= '0;
    end else if (lp_strobe) begin
      if (too_soon) begin
        run_q <= '0;
      end else if (too_late || run_q + CW'(1) >= GOAL) begin
        if (!too_late || LINK_COUNT <= 1) begin
          state_q <= LINK_UP;
          run_q   <= '0;
        end else begin
          run_q <= CW'(1);
        end
      end else begin
        run_q <= run_q + CW'(1);
      end
    end
  end

  assign link_ok    = (state_q == LINK_UP);
  assign path_block = !link_ok;

  assert_rise_on_event_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(link_ok) |-> $past(lp_strobe || rx_active || test_off));

  assert_fall_on_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(link_ok) |-> $past(!lp_strobe && !rx_active && !test_off));

  assert_early_holds_down_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!link_ok && lp_strobe && too_soon && !rx_active && !test_off) |=> !link_ok);

  assert_rx_recovers_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!link_ok && rx_active) |=> link_ok);

  assert_forced_up_R9: assert property (@(posedge clk) disable iff (!rst_n)
    test_off |=> link_ok);

  assert_run_bound_R4: assert property (@(posedge clk) disable iff (!rst_n)
    run_q < GOAL);

endmodule

// File: tb/test_tp_link_monitor.sv
module test_tp_link_monitor;
  localparam int CLK_HZ = 8000;
  localparam int LOSS   = 512;
  localparam int MINC   = 32;
  localparam int MAXC   = 512;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic lp_strobe = 1'b0;
  logic rx_active = 1'b0;
  logic test_off = 1'b0;
  logic link_ok, path_block;

  always #2 clk = ~clk;

  tp_link_monitor #(.CLK_HZ(CLK_HZ), .LOSS_MS(64), .MIN_GAP_MS(4),
                    .MAX_GAP_MS(64), .LINK_COUNT(2)) i_tp_link_monitor (
    .clk(clk), .rst_n(rst_n), .lp_strobe(lp_strobe), .rx_active(rx_active),
    .test_off(test_off), .link_ok(link_ok), .path_block(path_block)
  );

  typedef struct { int due; bit val; string tag; } exp_t;
  exp_t sb[$];
  int cyc = 0;
  int checks = 0;
  int fails = 0;
  bit done = 0;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic expect_at(input int due, input bit val, input string tag);
    exp_t e;
    e.due = due; e.val = val; e.tag = tag;
    sb.push_back(e);
  endtask

  // monitor: compare queued levels half a cycle after their edge
  always @(negedge clk) begin
    while (sb.size() > 0 && sb[0].due <= cyc) begin
      exp_t e;
      e = sb.pop_front();
      checks++;
      if (e.due < cyc) begin
        fails++;
        $display("FAIL %s: item due at edge %0d overdue (now %0d), actual link_ok=%0b expected=%0b",
                 e.tag, e.due, cyc, link_ok, e.val);
      end else if (link_ok !== e.val || path_block !== !e.val) begin
        fails++;
        $display("FAIL %s @edge %0d: actual link_ok=%0b path_block=%0b expected link_ok=%0b path_block=%0b (R8)",
                 e.tag, cyc, link_ok, path_block, e.val, !e.val);
      end
    end
  end

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  // drive one strobe (or activity) so that the edge cyc+gap samples it
  task automatic fire(input bit use_rx, input int gap);
    idle(gap - 1);
    if (use_rx) rx_active = 1'b1; else lp_strobe = 1'b1;
    @(negedge clk);
    rx_active = 1'b0;
    lp_strobe = 1'b0;
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog: run hung, actual=timeout expected=completion");
    finish_run();
  end

  initial begin
    int g;
    idle(3);
    rst_n = 1'b1;
    expect_at(cyc + 1, 1'b0, "R1 reset");
    expect_at(cyc + 3, 1'b0, "R1 reset");
    idle(4);

    // R6 first pulse starts a run; R4 second valid pulse brings the link up
    expect_at(cyc + 1, 1'b0, "R6 first pulse");
    fire(0, 1);
    expect_at(cyc + 39, 1'b0, "R4 before second pulse");
    expect_at(cyc + 40, 1'b1, "R4 second pulse");
    fire(0, 40);

    // R2 loss after silence
    g = cyc;
    expect_at(g + LOSS - 1, 1'b1, "R2 one edge before loss");
    expect_at(g + LOSS, 1'b0, "R2 loss edge");
    idle(LOSS + 4);

    // R5 early pulse empties the run and becomes the new reference
    expect_at(cyc + 1, 1'b0, "R6 restart after loss");
    fire(0, 1);
    expect_at(cyc + MINC - 1, 1'b0, "R5 early pulse");
    fire(0, MINC - 1);
    expect_at(cyc + 40, 1'b0, "R5 run restarted from zero");
    fire(0, 40);
    expect_at(cyc + MINC, 1'b1, "R4 spacing equal to minimum");
    fire(0, MINC);

    // R3 pulse and activity restart the loss window
    expect_at(cyc + 400, 1'b1, "R3 still up at pulse");
    fire(0, 400);
    g = cyc;
    expect_at(g + LOSS - 1, 1'b1, "R3 window restarted by pulse");
    fire(1, 300);
    g = cyc;
    expect_at(g + LOSS - 1, 1'b1, "R3 window restarted by activity");
    expect_at(g + LOSS, 1'b0, "R3 loss after activity");
    idle(LOSS + 4);

    // R6 late pulse restarts the run; R4 spacing equal to maximum is valid
    expect_at(cyc + 1, 1'b0, "R6 run start");
    fire(0, 1);
    expect_at(cyc + MAXC + 1, 1'b0, "R6 late pulse restarts");
    fire(0, MAXC + 1);
    expect_at(cyc + MAXC, 1'b1, "R4 spacing equal to maximum");
    fire(0, MAXC);
    expect_at(cyc + LOSS, 1'b0, "R2 loss again");
    idle(LOSS + 4);

    // R7 activity wins over a simultaneous pulse while down
    idle(4);
    lp_strobe = 1'b1;
    rx_active = 1'b1;
    expect_at(cyc + 1, 1'b1, "R7 activity recovers link");
    @(negedge clk);
    lp_strobe = 1'b0;
    rx_active = 1'b0;
    expect_at(cyc + LOSS, 1'b0, "R2 loss after activity recovery");
    idle(LOSS + 4);

    // R9 forced good during long silence
    test_off = 1'b1;
    expect_at(cyc + 1, 1'b1, "R9 forced up");
    expect_at(cyc + 1000, 1'b1, "R9 held up through silence");
    idle(1002);
    test_off = 1'b0;
    idle(4);

    done = 1'b1;
    if (sb.size() != 0) begin
      checks++;
      fails++;
      $display("FAIL scoreboard: actual %0d items left, expected 0", sb.size());
    end
    finish_run();
  end

endmodule